// File: doc/BRIEF.md
# Shadow-Register Interrupt Controller

This unit sits beside the execute stage of a small 32-bit processor. It handles interrupts without a CSR file. Interrupt state lives in four extra registers (q0..q3), an enable mask, a sticky pending vector, a countdown timer and a wait flag. Software reaches all of it through one family of custom instructions. Each cycle the unit decodes the presented instruction word together with the rs1 operand. Its combinational outputs then tell the core three things: what to write back to the integer register file, where to redirect the PC, and whether to stall.

When an enabled source is pending and no handler is running, the unit enters the handler in that same cycle. It discards the instruction presented in that cycle and redirects to a fixed handler address. It saves the core-supplied return address in q0 and the source number in q1. Registers q2 and q3 are left alone so the handler can use them as scratch space. A return instruction jumps back to q0 and allows the next entry. In the first cycle after reset the unit redirects the core to the program start address.

Top module: `irq_ctrl_unit`

## Requirements
- R1: In the first cycle after reset is released, redir_valid=1 with redir_pc=RESET_ADDR (default 0), wb_en=0 and stall=0. Reset clears q0..q3, the mask, the pending bits and the timer.
- R2: An instruction is recognised only when insn_valid=1, bits 6:0 = 0001011, bits 14:12 = 000 and bits 24:20 = 00000. Bits 31:25 then pick the operation. Any other word, or a reserved field that is not zero, is ignored: no writeback, no redirect, no state change.
- R3: Read-q (bits 31:25 = 0000000) takes the q index from bits 16:15 and requires bits 19:17 to be zero. In the same cycle it drives wb_en=1, wb_idx = bits 11:7 and wb_data = the selected q register.
- R4: Write-q (0000001) takes the q index from bits 8:7 and requires bits 11:9 to be zero. It loads rs1_val into that q register at the clock edge.
- R5: Mask (0000011) writes back the old mask, zero-extended, to rd (bits 11:7). It loads rs1_val[NIRQ-1:0] as the new mask. A set bit enables that source.
- R6: Return (0000010, bits 19:15 and 11:7 zero) redirects in the same cycle to the value of q0 and allows interrupt entry again from the next cycle.
- R7: Wait (0000100, bits 19:15 and 11:7 zero) raises stall from its own cycle up to, but not including, the entry cycle. Instructions presented while waiting are ignored.
- R8: Timer (0000101, bits 11:7 zero) loads the counter from rs1_val. A nonzero counter decrements once per clock. Stepping from 1 to 0 sets pending source TIMER_SRC (default 0). A load takes precedence over the decrement, and loading zero stops the counter.
- R9: A high interrupt line for one cycle sets its pending bit at the next edge. The bit stays set until that source is taken, including while it is masked.
- R10: Entry occurs in any cycle, other than the post-reset cycle, in which no handler is active and some source is both pending and enabled. That cycle drives redir_pc=HANDLER_ADDR (default 16) and discards the presented instruction. At the edge q0 takes ret_addr, q1 takes the source number and the taken pending bit clears, while q2 and q3 keep their values.
- R11: When several enabled sources are pending, the lowest numbered one is taken first.
- R12: After an entry, no further entry occurs until a return instruction has executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | The word on insn executes this cycle |
| insn | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of integer register rs1 |
| ret_addr | input | XLEN | Address to resume at if an entry happens this cycle |
| irq_lines | input | NIRQ | External interrupt request lines |
| wb_en | output | 1 | Integer register write enable |
| wb_idx | output | 5 | Integer register index |
| wb_data | output | XLEN | Integer register write data |
| redir_valid | output | 1 | PC redirect request |
| redir_pc | output | XLEN | Redirect target |
| stall | output | 1 | Hold the core |

## Verification
A vector table drives write-q and read-q pairs to distinct q registers, reads q0 while it still holds its reset value, and uses two mask writes to show that the old mask comes back on rd. The same table also drives words that differ from a legal one in a single field (opcode, funct3, funct5, or a reserved q-index bit). These must produce no writeback, and a later read-q shows that q2 was not overwritten. Directed sequences then pulse two lines at once to separate priority from blocking. One sequence holds a source masked for several cycles to show its pending bit survives. Another arms the timer while a wait is active, to check the stall window, the number in q1 and the resume address. Loading zero right after a nonzero load must cancel the pending interrupt.

// File: rtl/irqcu_pkg.sv
package irqcu_pkg;

   localparam logic [6:0] OPC_CUSTOM = 7'b0001011;

   localparam logic [6:0] F7_GETQ  = 7'b0000000;
   localparam logic [6:0] F7_SETQ  = 7'b0000001;
   localparam logic [6:0] F7_RETI  = 7'b0000010;
   localparam logic [6:0] F7_MASK  = 7'b0000011;
   localparam logic [6:0] F7_WAIT  = 7'b0000100;
   localparam logic [6:0] F7_TIMER = 7'b0000101;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_GETQ,
      OP_SETQ,
      OP_RETI,
      OP_MASK,
      OP_WAIT,
      OP_TIMER
   } op_e;

   typedef struct packed {
      op_e        op;
      logic [1:0] qidx;
      logic [4:0] rd;
   } dec_t;

endpackage

// File: rtl/irqcu_decode.sv
module irqcu_decode
   import irqcu_pkg::*;
(
   input  logic        insn_valid,
   input  logic [31:0] insn,
   output dec_t        dec
);

   logic [6:0] f7;
   logic [4:0] rs_f;
   logic [4:0] rd_f;
   logic       base_ok;

   always_comb begin
      f7      = insn[31:25];
      rs_f    = insn[19:15];
      rd_f    = insn[11:7];
      base_ok = insn_valid && (insn[6:0] == OPC_CUSTOM) &&
                (insn[14:12] == 3'b000) && (insn[24:20] == 5'd0);
      dec.op   = OP_NONE;
      dec.qidx = 2'd0;
      dec.rd   = rd_f;
      if (base_ok) begin
         unique case (f7)
            F7_GETQ: if (rs_f[4:2] == 3'd0) begin
               dec.op   = OP_GETQ;
               dec.qidx = rs_f[1:0];
            end
            F7_SETQ: if (rd_f[4:2] == 3'd0) begin
               dec.op   = OP_SETQ;
               dec.qidx = rd_f[1:0];
            end
            F7_RETI:  if (rs_f == 5'd0 && rd_f == 5'd0) dec.op = OP_RETI;
            F7_MASK:  dec.op = OP_MASK;
            F7_WAIT:  if (rs_f == 5'd0 && rd_f == 5'd0) dec.op = OP_WAIT;
            F7_TIMER: if (rd_f == 5'd0) dec.op = OP_TIMER;
            default:  dec.op = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/irqcu_timer.sv
module irqcu_timer #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         fire,
   output logic [W-1:0] cnt
);

   logic [W-1:0] cnt_q;

   assign cnt  = cnt_q;
   assign fire = !load && (cnt_q == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

endmodule

// File: rtl/irqcu_arbiter.sv
module irqcu_arbiter #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  gnt
);

   always_comb begin
      any = |req;
      idx = '0;
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx    = IW'(i);
            gnt    = '0;
            gnt[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
   import irqcu_pkg::*;
#(
   parameter int unsigned     XLEN         = 32,
   parameter int unsigned     NIRQ         = 8,
   parameter int unsigned     TIMER_SRC    = 0,
   parameter logic [XLEN-1:0] RESET_ADDR   = '0,
   parameter logic [XLEN-1:0] HANDLER_ADDR = XLEN'(16)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            insn_valid,
   input  logic [31:0]     insn,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] ret_addr,
   input  logic [NIRQ-1:0] irq_lines,
   output logic            wb_en,
   output logic [4:0]      wb_idx,
   output logic [XLEN-1:0] wb_data,
   output logic            redir_valid,
   output logic [XLEN-1:0] redir_pc,
   output logic            stall
);

   localparam int unsigned IW = $clog2(NIRQ);
   localparam int unsigned NQ = 4;

   generate
      if (NIRQ < 2 || NIRQ > XLEN) begin : g_bad_nirq
         $error("irq_ctrl_unit: NIRQ must lie in 2..XLEN");
      end
      if (TIMER_SRC >= NIRQ) begin : g_bad_tsrc
         $error("irq_ctrl_unit: TIMER_SRC must be below NIRQ");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("irq_ctrl_unit: XLEN too small");
      end
   endgenerate

   dec_t            dec;
   logic [XLEN-1:0] q_r [NQ];
   logic [NIRQ-1:0] mask_r, pend_r, fire_vec, grant;
   logic            in_hdl_r, wait_r, boot_r;
   logic            take, live, tmr_load, tmr_fire;
   logic [IW-1:0]   take_idx;
   logic [XLEN-1:0] tmr_cnt, mask_ext, num_ext;

   irqcu_decode u_dec (
      .insn_valid (insn_valid),
      .insn       (insn),
      .dec        (dec)
   );

   irqcu_arbiter #(.N(NIRQ), .IW(IW)) u_arb (
      .req (pend_r & mask_r & {NIRQ{!boot_r && !in_hdl_r}}),
      .any (take),
      .idx (take_idx),
      .gnt (grant)
   );

   irqcu_timer #(.W(XLEN)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (rs1_val),
      .fire     (tmr_fire),
      .cnt      (tmr_cnt)
   );

   always_comb begin
      live     = !boot_r && !wait_r && !take;
      tmr_load = live && (dec.op == OP_TIMER);
      fire_vec = '0;
      fire_vec[TIMER_SRC] = tmr_fire;
      mask_ext = '0;
      mask_ext[NIRQ-1:0] = mask_r;
      num_ext  = '0;
      num_ext[IW-1:0] = take_idx;

      wb_en   = live && (dec.op == OP_GETQ || dec.op == OP_MASK);
      wb_idx  = dec.rd;
      wb_data = (dec.op == OP_GETQ) ? q_r[dec.qidx] : mask_ext;

      redir_valid = boot_r || take || (live && dec.op == OP_RETI);
      if (boot_r)    redir_pc = RESET_ADDR;
      else if (take) redir_pc = HANDLER_ADDR;
      else           redir_pc = q_r[0];

      stall = (wait_r && !take) || (live && dec.op == OP_WAIT);
   end

   generate
      for (genvar g = 0; g < NQ; g++) begin : g_qreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q_r[g] <= '0;
            else if (take && g == 0)
               q_r[g] <= ret_addr;
            else if (take && g == 1)
               q_r[g] <= num_ext;
            else if (live && dec.op == OP_SETQ && dec.qidx == 2'(g))
               q_r[g] <= rs1_val;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_r   <= '0;
         pend_r   <= '0;
         in_hdl_r <= 1'b0;
         wait_r   <= 1'b0;
         boot_r   <= 1'b1;
      end else begin
         boot_r <= 1'b0;
         pend_r <= (pend_r | irq_lines | fire_vec) & ~grant;
         if (live && dec.op == OP_MASK) mask_r <= rs1_val[NIRQ-1:0];
         if (take)                           in_hdl_r <= 1'b1;
         else if (live && dec.op == OP_RETI) in_hdl_r <= 1'b0;
         if (take)                           wait_r <= 1'b0;
         else if (live && dec.op == OP_WAIT) wait_r <= 1'b1;
      end
   end

endmodule

// File: rtl/irqcu_chk.sv
module irqcu_chk #(
   parameter int unsigned     XLEN         = 32,
   parameter int unsigned     NIRQ         = 8,
   parameter logic [XLEN-1:0] HANDLER_ADDR = XLEN'(16)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            take,
   input logic            in_hdl,
   input logic            waiting,
   input logic            stall,
   input logic            wb_en,
   input logic            redir_valid,
   input logic [XLEN-1:0] redir_pc,
   input logic [XLEN-1:0] ret_addr,
   input logic [XLEN-1:0] q0,
   input logic [XLEN-1:0] q2,
   input logic [XLEN-1:0] q3,
   input logic [XLEN-1:0] tmr_cnt,
   input logic            tmr_load,
   input logic [NIRQ-1:0] grant
);

   AST_ENTRY_SAVES_RET: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> q0 == $past(ret_addr)); // R10

   AST_ENTRY_KEEPS_SCRATCH: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> $stable(q2) && $stable(q3)); // R10

   AST_ENTRY_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> redir_valid && redir_pc == HANDLER_ADDR && !wb_en); // R10

   AST_NO_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
      in_hdl |-> !take); // R12

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && !take) |-> stall && !wb_en); // R7

   AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_cnt == '0 && !tmr_load) |=> tmr_cnt == '0); // R8

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R11

endmodule

bind irq_ctrl_unit irqcu_chk #(
   .XLEN(XLEN), .NIRQ(NIRQ), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .take        (take),
   .in_hdl      (in_hdl_r),
   .waiting     (wait_r),
   .stall       (stall),
   .wb_en       (wb_en),
   .redir_valid (redir_valid),
   .redir_pc    (redir_pc),
   .ret_addr    (ret_addr),
   .q0          (q_r[0]),
   .q2          (q_r[2]),
   .q3          (q_r[3]),
   .tmr_cnt     (tmr_cnt),
   .tmr_load    (tmr_load),
   .grant       (grant)
);

// File: tb/sim_irq_ctrl_unit.sv
`timescale 1ns/1ps
module sim_irq_ctrl_unit;

   localparam real PER = 5.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [31:0] rs1_val = '0;
   logic [31:0] ret_addr = '0;
   logic [7:0]  irq_lines = '0;
   logic        wb_en, redir_valid, stall;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data, redir_pc;

   int n_chk = 0;
   int n_err = 0;

   always #(PER / 2) clk = ~clk;

   irq_ctrl_unit u0 (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
      .rs1_val(rs1_val), .ret_addr(ret_addr), .irq_lines(irq_lines),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .redir_valid(redir_valid), .redir_pc(redir_pc), .stall(stall)
   );

   function automatic logic [31:0] e_getq(input logic [1:0] q, input logic [4:0] rd);
      return {7'd0, 5'd0, 3'd0, q, 3'd0, rd, 7'b0001011};
   endfunction
   function automatic logic [31:0] e_setq(input logic [1:0] q, input logic [4:0] rs);
      return {7'd1, 5'd0, rs, 3'd0, 3'd0, q, 7'b0001011};
   endfunction
   function automatic logic [31:0] e_mask(input logic [4:0] rd, input logic [4:0] rs);
      return {7'd3, 5'd0, rs, 3'd0, rd, 7'b0001011};
   endfunction
   function automatic logic [31:0] e_timer(input logic [4:0] rs);
      return {7'd5, 5'd0, rs, 3'd0, 5'd0, 7'b0001011};
   endfunction
   localparam logic [31:0] E_RETI = {7'd2, 18'd0, 7'b0001011};
   localparam logic [31:0] E_WAIT = {7'd4, 18'd0, 7'b0001011};

   typedef struct packed {
      logic [15:0] tag;
      logic [31:0] ins;
      logic [31:0] rs;
      logic        wen;
      logic [4:0]  idx;
      logic [31:0] dat;
   } tv_t;

   localparam int NV = 13;
   localparam tv_t TV [NV] = '{
      '{"R4", e_setq(2'd2, 5'd3),            32'hA5A5_0001, 1'b0, 5'd0,  32'h0},
      '{"R4", e_setq(2'd3, 5'd4),            32'h1234_5678, 1'b0, 5'd0,  32'h0},
      '{"R3", e_getq(2'd2, 5'd5),            32'h0,         1'b1, 5'd5,  32'hA5A5_0001},
      '{"R3", e_getq(2'd3, 5'd31),           32'h0,         1'b1, 5'd31, 32'h1234_5678},
      '{"R1", e_getq(2'd0, 5'd1),            32'h0,         1'b1, 5'd1,  32'h0},
      '{"R3", e_getq(2'd2, 5'd5) | (1 << 17), 32'h0,        1'b0, 5'd0,  32'h0},
      '{"R2", e_getq(2'd2, 5'd5) | (1 << 12), 32'h0,        1'b0, 5'd0,  32'h0},
      '{"R2", e_getq(2'd2, 5'd5) ^ 32'h1,    32'h0,         1'b0, 5'd0,  32'h0},
      '{"R5", e_mask(5'd7, 5'd2),            32'h0000_00F0, 1'b1, 5'd7,  32'h0},
      '{"R5", e_mask(5'd8, 5'd2),            32'h0,         1'b1, 5'd8,  32'h0000_00F0},
      '{"R4", e_setq(2'd2, 5'd3) | (1 << 9), 32'hDEAD,      1'b0, 5'd0,  32'h0},
      '{"R4", e_getq(2'd2, 5'd3),            32'h0,         1'b1, 5'd3,  32'hA5A5_0001},
      '{"R2", e_getq(2'd2, 5'd5) | (1 << 20), 32'h0,        1'b0, 5'd0,  32'h0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic v, input logic [31:0] ins, input logic [31:0] rs,
                      input logic [31:0] ra, input logic [7:0] irq);
      @(negedge clk);
      insn_valid = v; insn = ins; rs1_val = rs; ret_addr = ra; irq_lines = irq;
      #1;
   endtask

   task automatic idle(input logic [31:0] ra);
      cyc(1'b0, 32'h0, 32'h0, ra, 8'h0);
   endtask

   initial begin
      #(PER * 20000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 boot redirect", {31'd0, redir_valid}, 32'd1);
      chk("R1 boot target", redir_pc, 32'h0);
      chk("R1 boot no wb", {31'd0, wb_en}, 32'd0);
      chk("R1 boot no stall", {31'd0, stall}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         cyc(1'b1, TV[i].ins, TV[i].rs, 32'h0, 8'h0);
         chk(string'(TV[i].tag), {31'd0, wb_en}, {31'd0, TV[i].wen});
         if (TV[i].wen) begin
            chk(string'(TV[i].tag), {27'd0, wb_idx}, {27'd0, TV[i].idx});
            chk(string'(TV[i].tag), wb_data, TV[i].dat);
         end
         chk("R2 no redirect", {31'd0, redir_valid}, 32'd0);
      end

      // R10 R11 R12: two sources at once, then return
      cyc(1'b1, e_mask(5'd0, 5'd1), 32'hFF, 32'h0, 8'h0);
      chk("R5 old mask", wb_data, 32'h0);
      cyc(1'b0, 32'h0, 32'h0, 32'h0, 8'h14);
      chk("R9 not yet pending", {31'd0, redir_valid}, 32'd0);
      cyc(1'b1, e_getq(2'd2, 5'd5), 32'h0, 32'h100, 8'h0);
      chk("R10 entry redirect", {31'd0, redir_valid}, 32'd1);
      chk("R10 handler addr", redir_pc, 32'd16);
      chk("R10 insn discarded", {31'd0, wb_en}, 32'd0);
      cyc(1'b1, e_getq(2'd0, 5'd6), 32'h0, 32'h0, 8'h0);
      chk("R10 q0 return", wb_data, 32'h100);
      chk("R12 no nested entry", {31'd0, redir_valid}, 32'd0);
      cyc(1'b1, e_getq(2'd1, 5'd6), 32'h0, 32'h0, 8'h0);
      chk("R11 lowest first", wb_data, 32'd2);
      cyc(1'b1, e_getq(2'd2, 5'd6), 32'h0, 32'h0, 8'h0);
      chk("R10 q2 kept", wb_data, 32'hA5A5_0001);
      chk("R12 still blocked", {31'd0, redir_valid}, 32'd0);
      cyc(1'b1, E_RETI, 32'h0, 32'h0, 8'h0);
      chk("R6 return redirect", {31'd0, redir_valid}, 32'd1);
      chk("R6 return target", redir_pc, 32'h100);
      idle(32'h200);
      chk("R11 second source taken", redir_pc, 32'd16);
      chk("R12 entry after return", {31'd0, redir_valid}, 32'd1);
      cyc(1'b1, e_getq(2'd1, 5'd1), 32'h0, 32'h0, 8'h0);
      chk("R11 second number", wb_data, 32'd4);
      cyc(1'b1, E_RETI, 32'h0, 32'h0, 8'h0);
      chk("R6 second return", redir_pc, 32'h200);
      idle(32'h0);
      chk("R9 nothing left", {31'd0, redir_valid}, 32'd0);

      // R9 R5: a masked source stays pending
      cyc(1'b1, e_mask(5'd9, 5'd1), 32'h0, 32'h0, 8'h0);
      chk("R5 old mask ff", wb_data, 32'hFF);
      cyc(1'b0, 32'h0, 32'h0, 32'h0, 8'h40);
      idle(32'h0);
      chk("R9 masked no entry", {31'd0, redir_valid}, 32'd0);
      idle(32'h0);
      chk("R9 masked no entry 2", {31'd0, redir_valid}, 32'd0);
      cyc(1'b1, e_mask(5'd9, 5'd1), 32'h40, 32'h0, 8'h0);
      chk("R5 mask takes effect next", {31'd0, redir_valid}, 32'd0);
      idle(32'h300);
      chk("R9 kept pending taken", {31'd0, redir_valid}, 32'd1);
      cyc(1'b1, e_getq(2'd1, 5'd2), 32'h0, 32'h0, 8'h0);
      chk("R9 source six", wb_data, 32'd6);
      cyc(1'b1, E_RETI, 32'h0, 32'h0, 8'h0);
      chk("R6 third return", redir_pc, 32'h300);

      // R8 R7: timer wakes a wait
      cyc(1'b1, e_mask(5'd0, 5'd1), 32'h01, 32'h0, 8'h0);
      cyc(1'b1, e_timer(5'd1), 32'd3, 32'h0, 8'h0);
      chk("R8 load no stall", {31'd0, stall}, 32'd0);
      cyc(1'b1, E_WAIT, 32'h0, 32'h0, 8'h0);
      chk("R7 stall at wait", {31'd0, stall}, 32'd1);
      cyc(1'b1, e_getq(2'd2, 5'd5), 32'h0, 32'h0, 8'h0);
      chk("R7 ignored while waiting", {31'd0, wb_en}, 32'd0);
      chk("R7 still stalled", {31'd0, stall}, 32'd1);
      idle(32'h0);
      chk("R8 not yet fired", {31'd0, redir_valid}, 32'd0);
      idle(32'h400);
      chk("R8 timer entry", {31'd0, redir_valid}, 32'd1);
      chk("R7 stall released", {31'd0, stall}, 32'd0);
      cyc(1'b1, e_getq(2'd1, 5'd3), 32'h0, 32'h0, 8'h0);
      chk("R8 timer source number", wb_data, 32'd0);
      cyc(1'b1, E_RETI, 32'h0, 32'h0, 8'h0);
      chk("R6 timer return", redir_pc, 32'h400);

      // R8: loading zero cancels
      cyc(1'b1, e_timer(5'd1), 32'd2, 32'h0, 8'h0);
      cyc(1'b1, e_timer(5'd1), 32'd0, 32'h0, 8'h0);
      for (int k = 0; k < 4; k++) begin
         idle(32'h0);
         chk("R8 zero disables", {31'd0, redir_valid}, 32'd0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule